// File: doc/BRIEF.md
# Floating-Point Status Word Update Unit

This unit keeps the 16-bit status word of a stack-organised floating-point unit. The execution pipeline sends it one set of event strobes per instruction: initialise, push, pop, read of the stack top, remainder step finished or incomplete, tangent argument in or out of range, and a direct write of the condition codes. The unit folds these strobes into the condition codes, the sticky exception flags and the stack-top pointer. A store instruction can read the result in every cycle on `statusWord`.

An eight-slot register stack is modelled through the pointer and one occupancy bit per slot. Overflow and underflow are found in hardware. A fault leaves the stack alone, raises the invalid-operation and stack-fault flags, and writes the fault direction into C1. The error-summary and busy bits are recomputed combinationally against a mask supplied by the control-word logic outside this block.

Top module: `fsw_update_unit`

## Requirements
- R1: While `rstN` is low, and on the clock edge after `initCmd`, the status word becomes 0: condition codes, pointer, exception flags and stack-fault bit are all cleared, and every slot is marked empty. `initCmd` overrides every other strobe in the same cycle.
- R2: Condition codes sit at C0 = bit 8, C1 = bit 9, C2 = bit 10 and C3 = bit 14. `ccWrEn` loads `ccWrData[i]` into Ci.
- R3: `remIncomplete` clears C0, C1 and C3 and sets C2 to 1.
- R4: `remDone` loads C0, C1 and C3 from `ccWrData[0]`, `ccWrData[1]` and `ccWrData[3]`, and clears C2.
- R5: `tanOutRange` sets C2 and `tanInRange` clears C2. The other condition codes are left unchanged.
- R6: The stack pointer sits in bits 13:11. A push decrements it modulo 8 and marks the new top slot valid. A pop marks the current top slot empty and increments the pointer modulo 8.
- R7: A push whose target slot (pointer minus 1) is already valid is an overflow. It sets bit 0, bit 6 and C1, and leaves the pointer and slot occupancy unchanged.
- R8: A pop or read while the top slot is empty is an underflow. It sets bit 0 and bit 6, clears C1, and leaves the pointer and slot occupancy unchanged. When both fault kinds could occur, underflow is reported.
- R9: Exception bits 5:0 OR in `excSet` and stay set. Bits 5:0 and bit 6 are cleared only by reset, `initCmd` or `excClr`. Flags raised in the same cycle as `excClr` survive the clear.
- R10: Bit 7 is the OR of exception bits 5:0 whose `excMask` bit is 0, and bit 15 equals bit 7. Both follow `excMask` in the same cycle.
- R11: After initialise, a stack fault takes priority: it suppresses the stack move and any condition-code update, except C1. If push and pop arrive together, the pop is done and the push is ignored. Among condition-code updates the order is `remIncomplete`, `remDone`, `tanOutRange`, `tanInRange`, `ccWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| initCmd | input | 1 | Initialise the status word and the stack |
| pushReq | input | 1 | Instruction pushes a stack entry |
| popReq | input | 1 | Instruction pops the stack top |
| readReq | input | 1 | Instruction reads the stack top |
| remDone | input | 1 | Remainder step complete, quotient bits on ccWrData |
| remIncomplete | input | 1 | Remainder step incomplete |
| tanInRange | input | 1 | Tangent completed in range |
| tanOutRange | input | 1 | Tangent operand out of range |
| ccWrEn | input | 1 | Write all four condition codes |
| ccWrData | input | 4 | Condition-code data, bit i for Ci |
| excSet | input | 6 | Exception flags raised this cycle |
| excClr | input | 1 | Clear sticky exception and stack-fault flags |
| excMask | input | 6 | Exception mask, 1 = masked |
| statusWord | output | 16 | Current status word |

## Verification
Every piece of internal state is visible in the status word the cycle after the edge that changed it. The exception is slot occupancy, which shows up only later. A wrong occupancy bit stays hidden until a push or pop reaches that slot, and then appears as a false or missing fault in bits 0, 6 and 9. For this reason the sweeps fill and drain the whole stack and then push and pop one step past each end. A long pseudo-random run drives the strobes against a requirement-level model, which exposes wrong priority between simultaneous events within one cycle.

// File: rtl/fsw_pkg.sv
`timescale 1ns/1ps
package fsw_pkg;

  localparam int SW_W   = 16;
  localparam int CC_W   = 4;
  localparam int BIT_SF = 6;
  localparam int BIT_ES = 7;
  localparam int BIT_C0 = 8;
  localparam int BIT_C1 = 9;
  localparam int BIT_C2 = 10;
  localparam int BIT_TOP_LO = 11;
  localparam int BIT_C3 = 14;
  localparam int BIT_BUSY = 15;

  typedef enum logic [2:0] {
    CC_HOLD,
    CC_LOAD,
    CC_REM_DONE,
    CC_REM_PART,
    CC_TAN_OK,
    CC_TAN_OOR
  } ccOp_e;

  typedef struct packed {
    logic  clearAll;
    logic  excClear;
    logic  stackFault;
    logic  faultOver;
    logic  doPush;
    logic  doPop;
    ccOp_e ccOp;
  } fswStrobes_t;

endpackage

// File: rtl/fsw_ctrl.sv
`timescale 1ns/1ps
module fsw_ctrl
  import fsw_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              initCmd,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              readReq,
  input  logic              remDone,
  input  logic              remIncomplete,
  input  logic              tanInRange,
  input  logic              tanOutRange,
  input  logic              ccWrEn,
  input  logic              excClr,
  input  logic [PTR_W-1:0]  stackTop,
  input  logic [DEPTH-1:0]  slotValid,
  output fswStrobes_t       strobes
);

  logic [PTR_W-1:0] pushSlot;
  logic             underflow;
  logic             overflow;
  logic             fault;

  // Slot a push would occupy; the pointer wraps naturally at DEPTH.
  assign pushSlot  = stackTop - PTR_W'(1);
  // Underflow is checked first so it wins over a concurrent overflow.
  assign underflow = (popReq | readReq) & ~slotValid[stackTop];
  assign overflow  = ~underflow & pushReq & ~popReq & slotValid[pushSlot];
  assign fault     = underflow | overflow;

  always_comb begin
    strobes = '0;
    strobes.ccOp = CC_HOLD;
    if (initCmd) begin
      strobes.clearAll = 1'b1;
    end else begin
      strobes.excClear   = excClr;
      strobes.stackFault = fault;
      strobes.faultOver  = overflow;
      if (!fault) begin
        strobes.doPop  = popReq;
        strobes.doPush = pushReq & ~popReq;
        if (remIncomplete)    strobes.ccOp = CC_REM_PART;
        else if (remDone)     strobes.ccOp = CC_REM_DONE;
        else if (tanOutRange) strobes.ccOp = CC_TAN_OOR;
        else if (tanInRange)  strobes.ccOp = CC_TAN_OK;
        else if (ccWrEn)      strobes.ccOp = CC_LOAD;
      end
    end
  end

endmodule

// File: rtl/fsw_datapath.sv
`timescale 1ns/1ps
module fsw_datapath
  import fsw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int EXC_W = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fswStrobes_t       strobes,
  input  logic [CC_W-1:0]   ccWrData,
  input  logic [EXC_W-1:0]  excSet,
  input  logic [EXC_W-1:0]  excMask,
  output logic [PTR_W-1:0]  stackTop,
  output logic [DEPTH-1:0]  slotValid,
  output logic [SW_W-1:0]   statusWord
);

  logic [PTR_W-1:0] topQ, topD, pushSlot;
  logic [DEPTH-1:0] validQ, validD;
  logic [CC_W-1:0]  ccQ, ccD;
  logic [EXC_W-1:0] excQ, excD;
  logic             sfQ, sfD;
  logic             errSummary;

  assign pushSlot = topQ - PTR_W'(1);

  // Pointer next state
  always_comb begin
    topD = topQ;
    if (strobes.clearAll)    topD = '0;
    else if (strobes.doPush) topD = pushSlot;
    else if (strobes.doPop)  topD = topQ + PTR_W'(1);
  end

  // One occupancy bit per slot
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_comb begin
      validD[gi] = validQ[gi];
      if (strobes.clearAll)
        validD[gi] = 1'b0;
      else if (strobes.doPush && pushSlot == PTR_W'(gi))
        validD[gi] = 1'b1;
      else if (strobes.doPop && topQ == PTR_W'(gi))
        validD[gi] = 1'b0;
    end
  end

  // Sticky flags: clear first, then merge this cycle's events
  always_comb begin
    excD = (strobes.excClear ? '0 : excQ) | excSet;
    sfD  = strobes.excClear ? 1'b0 : sfQ;
    if (strobes.stackFault) begin
      excD[0] = 1'b1;
      sfD     = 1'b1;
    end
    if (strobes.clearAll) begin
      excD = '0;
      sfD  = 1'b0;
    end
  end

  // Condition codes
  always_comb begin
    ccD = ccQ;
    if (strobes.clearAll) begin
      ccD = '0;
    end else if (strobes.stackFault) begin
      ccD[1] = strobes.faultOver;
    end else begin
      unique case (strobes.ccOp)
        CC_LOAD:     ccD = ccWrData;
        CC_REM_DONE: ccD = {ccWrData[3], 1'b0, ccWrData[1:0]};
        CC_REM_PART: ccD = 4'b0100;
        CC_TAN_OK:   ccD[2] = 1'b0;
        CC_TAN_OOR:  ccD[2] = 1'b1;
        default:     ccD = ccQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topQ   <= '0;
      validQ <= '0;
      ccQ    <= '0;
      excQ   <= '0;
      sfQ    <= 1'b0;
    end else begin
      topQ   <= topD;
      validQ <= validD;
      ccQ    <= ccD;
      excQ   <= excD;
      sfQ    <= sfD;
    end
  end

  assign errSummary = |(excQ & ~excMask);

  always_comb begin
    statusWord = '0;
    statusWord[EXC_W-1:0]                    = excQ;
    statusWord[BIT_SF]                       = sfQ;
    statusWord[BIT_ES]                       = errSummary;
    statusWord[BIT_C0]                       = ccQ[0];
    statusWord[BIT_C1]                       = ccQ[1];
    statusWord[BIT_C2]                       = ccQ[2];
    statusWord[BIT_TOP_LO +: PTR_W]          = topQ;
    statusWord[BIT_C3]                       = ccQ[3];
    statusWord[BIT_BUSY]                     = errSummary;
  end

  assign stackTop  = topQ;
  assign slotValid = validQ;

  // Initialise empties everything (R1)
  a_r1_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (topQ == '0 && validQ == '0 && ccQ == '0 && excQ == '0 && !sfQ));

  // Push steps the pointer down by one (R6)
  a_r6_push_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doPush |=> topQ == PTR_W'($past(topQ) - PTR_W'(1)));

  // Pop steps the pointer up by one (R6)
  a_r6_pop_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doPop |=> topQ == PTR_W'($past(topQ) + PTR_W'(1)));

  // Overflow raises IE, SF and C1 (R7)
  a_r7_overflow_flags: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stackFault && strobes.faultOver && !strobes.clearAll) |=> (excQ[0] && sfQ && ccQ[1]));

  // Underflow raises IE and SF with C1 clear (R8)
  a_r8_underflow_flags: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stackFault && !strobes.faultOver && !strobes.clearAll) |=> (excQ[0] && sfQ && !ccQ[1]));

  // A fault leaves the stack untouched (R8)
  a_r8_fault_holds_stack: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stackFault && !strobes.clearAll) |=> (topQ == $past(topQ) && validQ == $past(validQ)));

  // Exception flags never drop without a clear (R9)
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clearAll && !strobes.excClear) |=> ((excQ & $past(excQ)) == $past(excQ)));

  // Out-of-range tangent raises C2 (R5)
  a_r5_tan_oor: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ccOp == CC_TAN_OOR && !strobes.stackFault && !strobes.clearAll) |=> ccQ[2]);

endmodule

// File: rtl/fsw_update_unit.sv
`timescale 1ns/1ps
module fsw_update_unit
  import fsw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int EXC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initCmd,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              readReq,
  input  logic              remDone,
  input  logic              remIncomplete,
  input  logic              tanInRange,
  input  logic              tanOutRange,
  input  logic              ccWrEn,
  input  logic [3:0]        ccWrData,
  input  logic [EXC_W-1:0]  excSet,
  input  logic              excClr,
  input  logic [EXC_W-1:0]  excMask,
  output logic [15:0]       statusWord
);

  localparam int PTR_W = $clog2(DEPTH);

  fswStrobes_t      strobes;
  logic [PTR_W-1:0] stackTop;
  logic [DEPTH-1:0] slotValid;

  fsw_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .initCmd       (initCmd),
    .pushReq       (pushReq),
    .popReq        (popReq),
    .readReq       (readReq),
    .remDone       (remDone),
    .remIncomplete (remIncomplete),
    .tanInRange    (tanInRange),
    .tanOutRange   (tanOutRange),
    .ccWrEn        (ccWrEn),
    .excClr        (excClr),
    .stackTop      (stackTop),
    .slotValid     (slotValid),
    .strobes       (strobes)
  );

  fsw_datapath #(.DEPTH(DEPTH), .EXC_W(EXC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ccWrData   (ccWrData),
    .excSet     (excSet),
    .excMask    (excMask),
    .stackTop   (stackTop),
    .slotValid  (slotValid),
    .statusWord (statusWord)
  );

endmodule

// File: tb/tb_fsw_update_unit.sv
`timescale 1ns/1ps
module tb_fsw_update_unit;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, initCmd, pushReq, popReq, readReq, remDone, remIncomplete;
  logic tanInRange, tanOutRange, ccWrEn, excClr;
  logic [3:0]  ccWrData;
  logic [5:0]  excSet, excMask;
  logic [15:0] statusWord;

  fsw_update_unit dut (
    .clk(clk), .rstN(rstN), .initCmd(initCmd), .pushReq(pushReq), .popReq(popReq),
    .readReq(readReq), .remDone(remDone), .remIncomplete(remIncomplete),
    .tanInRange(tanInRange), .tanOutRange(tanOutRange), .ccWrEn(ccWrEn),
    .ccWrData(ccWrData), .excSet(excSet), .excClr(excClr), .excMask(excMask),
    .statusWord(statusWord)
  );

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  // Requirement-level model
  logic [2:0] mTop;
  logic [7:0] mValid;
  logic [3:0] mCc;
  logic [5:0] mExc;
  logic       mSf;

  function automatic logic [15:0] expSw();
    logic es;
    es = |(mExc & ~excMask);
    return {es, mCc[3], mTop, mCc[2], mCc[1], mCc[0], es, mSf, mExc};
  endfunction

  task automatic check(string req);
    vectors++;
    if (statusWord !== expSw()) begin
      misses++;
      $display("FAIL %s: statusWord actual %h expected %h", req, statusWord, expSw());
    end
  endtask

  task automatic modelReset();
    mTop = '0; mValid = '0; mCc = '0; mExc = '0; mSf = 1'b0;
  endtask

  task automatic modelStep();
    logic under, over;
    logic [2:0] ps;
    ps = mTop - 3'd1;
    under = (popReq | readReq) && !mValid[mTop];
    over  = !under && pushReq && !popReq && mValid[ps];
    if (initCmd) begin
      modelReset();
    end else begin
      mExc = (excClr ? 6'd0 : mExc) | excSet;
      if (excClr) mSf = 1'b0;
      if (under || over) begin
        mExc[0] = 1'b1; mSf = 1'b1; mCc[1] = over;
      end else begin
        if (popReq) begin mValid[mTop] = 1'b0; mTop = mTop + 3'd1; end
        else if (pushReq) begin mValid[ps] = 1'b1; mTop = ps; end
        if (remIncomplete) mCc = 4'b0100;
        else if (remDone) mCc = {ccWrData[3], 1'b0, ccWrData[1:0]};
        else if (tanOutRange) mCc[2] = 1'b1;
        else if (tanInRange) mCc[2] = 1'b0;
        else if (ccWrEn) mCc = ccWrData;
      end
    end
  endtask

  task automatic idle();
    initCmd = 0; pushReq = 0; popReq = 0; readReq = 0; remDone = 0; remIncomplete = 0;
    tanInRange = 0; tanOutRange = 0; ccWrEn = 0; excClr = 0; excSet = '0;
  endtask

  task automatic tick(string req);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    idle();
    check(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; idle(); excMask = '0; ccWrData = '0;
    modelReset();
    repeat (2) @(negedge clk);
    check("R1");
    rstN = 1'b1;

    // R2: every condition-code pattern lands in bits 8,9,10,14
    for (int v = 0; v < 16; v++) begin
      ccWrEn = 1; ccWrData = 4'(v); tick("R2");
    end

    // R3 / R4: remainder steps
    ccWrEn = 1; ccWrData = 4'hF; tick("R2");
    remIncomplete = 1; tick("R3");
    ccWrData = 4'b1011; remDone = 1; tick("R4");
    ccWrData = 4'b0110; remDone = 1; tick("R4");
    remIncomplete = 1; remDone = 1; ccWrEn = 1; tick("R3 R11");

    // R5: tangent range checks
    ccWrEn = 1; ccWrData = 4'b1011; tick("R2");
    tanOutRange = 1; tick("R5");
    tanInRange = 1; tick("R5");
    tanOutRange = 1; tanInRange = 1; tick("R5 R11");

    // R6 / R7: fill the stack, then overflow
    initCmd = 1; tick("R1");
    for (int i = 0; i < 8; i++) begin
      pushReq = 1; tick("R6");
    end
    pushReq = 1; ccWrEn = 1; ccWrData = 4'h5; tick("R7 R11");
    excClr = 1; tick("R9");
    popReq = 1; pushReq = 1; tick("R11");
    for (int i = 0; i < 7; i++) begin
      popReq = 1; tick("R6");
    end
    popReq = 1; tick("R8");
    excClr = 1; tick("R9");
    readReq = 1; tanOutRange = 1; tick("R8 R11");
    pushReq = 1; tick("R6");
    readReq = 1; tick("R8");
    pushReq = 1; readReq = 1; tick("R6");

    // R9: sticky flags
    initCmd = 1; tick("R1");
    for (int b = 0; b < 6; b++) begin
      excSet = 6'(1 << b); tick("R9");
      tick("R9");
    end
    excClr = 1; excSet = 6'b000010; tick("R9");
    excSet = 6'b101101; tick("R9");

    // R10: every mask against fixed flags, combinational response
    for (int m = 0; m < 64; m++) begin
      @(negedge clk);
      excMask = 6'(m);
      #1;
      check("R10");
    end
    excMask = '0;

    // R1 / R11: initialise beats everything
    pushReq = 1; popReq = 1; ccWrEn = 1; ccWrData = 4'hF; excSet = 6'h3F; initCmd = 1;
    tick("R1 R11");

    // Pseudo-random mix of all strobes
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom();
      initCmd       = (r[31:27] == 5'd0);
      pushReq       = (r[2:0] < 3'd3);
      popReq        = (r[5:3] < 3'd3);
      readReq       = r[6] & r[7];
      remDone       = r[8] & r[9] & r[10];
      remIncomplete = r[11] & r[12] & r[13];
      tanInRange    = r[14] & r[15] & r[16];
      tanOutRange   = r[17] & r[18] & r[19];
      ccWrEn        = r[20];
      ccWrData      = r[24:21];
      excSet        = (r[26:25] == 2'd0) ? r[12:7] : 6'd0;
      excClr        = (r[30:28] == 3'd0);
      excMask       = r[31:26];
      tick("R11");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule